// File: doc/BRIEF.md
# JTAG Target Memory Access Sequencer

This block is a hardware test-port master. It reads or writes one byte or one word in a target's memory over a four-wire JTAG link. A separate target clock output steps the target's memory logic. The host gives a read/write select, a 20-bit address and 16-bit write data, then pulses start. The block runs a fixed script of instruction shifts, data shifts and target-clock edges. When the script ends it pulses done, together with an error flag and, for reads, the 16-bit value it fetched.

Every access first asks the target for its control status. The access goes on only when the target reports that it is ready. Addresses below a parameterised limit (default 0x100) use byte mode. All other addresses use word mode. The mode sets the control word that is sent.

Inside the block, a TAP walker produces TCK from the system clock divided by a parameter, and produces TMS and TDI. It performs 8-bit instruction shifts and 16-bit or 20-bit data shifts, always starting and ending in Run-Test/Idle. A script table holds each access as a list of steps. A controller steps through that list. The instruction opcodes are parameters.

Top module: `jtag_mem_seq`

## Requirements
- R1: Every access begins with the status-capture instruction followed by a 16-bit data shift of zeros. The access continues only if the captured 16-bit value ANDed with 0x0301 is nonzero.
- R2: On a read whose status check fails, the check (instruction plus 16-bit zero shift) is repeated. This continues up to MAX_POLLS checks in total. If all of them fail, done is signalled with the error flag set and read data 0xBABE, and the target clock never moves.
- R3: On a write, one failed status check ends the command. Done is signalled with the error flag set, and no further shift or target-clock edge follows.
- R4: An address below 0x100 selects byte mode, and any other address selects word mode. The control word is 0x0510 for a byte write, 0x0500 for a word write, 0x0511 for a byte read and 0x0501 for a word read.
- R5: The address is sent as a 20-bit data shift directly after the address instruction.
- R6: A write runs in this order after the status check:
  - target clock low
  - control instruction, then the control word
  - address instruction, then the 20-bit address
  - target clock high
  - data-to-address instruction, then the 16-bit write data
  - target clock low
  - control instruction, then 0x0501
  - target clock high, then one more low/high pulse
- R7: A read runs in this order after the status check:
  - target clock low
  - control instruction, then the control word
  - address instruction, then the 20-bit address
  - data-to-address instruction
  - target clock high, then target clock low
  - a 16-bit zero data shift, whose captured value becomes the read data
  - target clock high, then one more low/high pulse
- R8: Each shift uses the standard TAP path from Run-Test/Idle through Shift-IR or Shift-DR back to Run-Test/Idle. Instruction shifts are 8 bits and data shifts are 16 or 20 bits, all least significant bit first. TMS and TDI change only while TCK is low, and TCK rests low when no shift is running.
- R9: After reset, the target clock is high. The target clock changes only while no shift is in progress.
- R10: Start is taken only while the block is idle. A start pulse during a command has no effect on that command. Busy stays high until the command ends. Done is a single-cycle pulse with busy low. The error flag and read data hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Begin a command (taken when idle) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Target memory address |
| cmd_wdata | input | DATA_W | Data to write |
| cmd_busy | output | 1 | Command in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Target was not ready; command abandoned |
| cmd_rdata | output | DATA_W | Value read, or 0xBABE after a failed read |
| jtag_tck | output | 1 | Test clock |
| jtag_tms | output | 1 | Test mode select |
| jtag_tdi | output | 1 | Test data to the target |
| jtag_tdo | input | 1 | Test data from the target |
| tgt_clk | output | 1 | Target memory clock line |

## Verification
The commands sweep addresses on both sides of the byte/word limit, including the extremes 0x00000 and 0xFFFFF, in both directions. This separates the four control words and shows that the 20-bit address arrives intact. The status returned for each command changes between the three mask bits, so an AND with the wrong mask is caught. The not-ready value sets only bits outside the mask. The number of not-ready replies per command is varied from zero up to more than the poll limit. This separates a read that retries and succeeds, a read that gives up with 0xBABE, and a write that stops after one failed check. A behavioural TAP target records every instruction update, every data update with its length, and every target-clock edge. Each command's log is compared with the expected order, so swapped steps or a target-clock edge in the wrong place are detected.

// File: rtl/jmseq_pkg.sv
package jmseq_pkg;

   // Kinds of step in an access script
   typedef enum logic [2:0] {
      OP_IR,      // instruction shift
      OP_DR_D,    // data-width data shift
      OP_DR_A,    // address-width data shift
      OP_CLK_LO,  // drive target clock low
      OP_CLK_HI,  // drive target clock high
      OP_CHECK,   // test captured status
      OP_END      // command complete
   } op_kind_e;

   typedef struct packed {
      op_kind_e    kind;
      logic        keep;  // captured data becomes read data
      logic [31:0] val;   // value shifted out
   } op_t;

   localparam logic [15:0] READY_MASK = 16'h0301;
   localparam logic [15:0] CW_WR_BYTE = 16'h0510;
   localparam logic [15:0] CW_WR_WORD = 16'h0500;
   localparam logic [15:0] CW_RD_BYTE = 16'h0511;
   localparam logic [15:0] CW_RD_WORD = 16'h0501;
   localparam logic [15:0] CW_RELEASE = 16'h0501;
   localparam logic [15:0] FAIL_WORD  = 16'hBABE;

endpackage

// File: rtl/jmseq_tap_walker.sv
module jmseq_tap_walker #(
   parameter int MAX_LEN  = 20,
   parameter int HALF_DIV = 2,
   localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic               is_ir,
   input  logic [LEN_W-1:0]   len,
   input  logic [MAX_LEN-1:0] din,
   output logic               busy,
   output logic               done,
   output logic [MAX_LEN-1:0] dout,
   output logic               tck,
   output logic               tms,
   output logic               tdi,
   input  logic               tdo
);

   localparam int STEP_W = $clog2(MAX_LEN + 8);

   logic               busy_q, done_q, tck_q, ir_q, tick;
   logic [STEP_W-1:0]  step_q, pre_s, len_s, last_s;
   logic [LEN_W-1:0]   len_q;
   logic [MAX_LEN-1:0] sh_q, cap_q, dout_q;
   logic               bit_step;

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   // Half-period tick: a constant tick or a divider counter
   if (HALF_DIV == 1) begin : g_tick_fast
      assign tick = 1'b1;
   end else begin : g_tick_div
      localparam int DW = $clog2(HALF_DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           div_q <= '0;
         else if (!busy_q)                     div_q <= '0;
         else if (div_q == DW'(HALF_DIV - 1))  div_q <= '0;
         else                                  div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DW'(HALF_DIV - 1));
   end

   assign pre_s    = ir_q ? STEP_W'(4) : STEP_W'(3);
   assign len_s    = STEP_W'(len_q);
   assign last_s   = pre_s + len_s + STEP_W'(1);
   assign bit_step = (step_q >= pre_s) && (step_q < pre_s + len_s);

   always_comb begin
      tms = 1'b0;
      tdi = 1'b0;
      if (busy_q) begin
         if (step_q < pre_s) begin
            tms = ir_q ? (step_q < STEP_W'(2)) : (step_q == '0);
         end else if (bit_step) begin
            tms = (step_q == pre_s + len_s - STEP_W'(1));
            tdi = sh_q[0];
         end else begin
            tms = (step_q == pre_s + len_s);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         tck_q  <= 1'b0;
         ir_q   <= 1'b0;
         step_q <= '0;
         len_q  <= '0;
         sh_q   <= '0;
         cap_q  <= '0;
         dout_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (go) begin
               busy_q <= 1'b1;
               step_q <= '0;
               tck_q  <= 1'b0;
               ir_q   <= is_ir;
               len_q  <= len;
               sh_q   <= din;
               cap_q  <= '0;
            end
         end else if (tick) begin
            if (!tck_q) begin
               tck_q <= 1'b1;
               if (bit_step) cap_q <= {tdo, cap_q[MAX_LEN-1:1]};
            end else begin
               tck_q <= 1'b0;
               if (bit_step) sh_q <= sh_q >> 1;
               if (step_q == last_s) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  dout_q <= cap_q >> (MAX_LEN - int'(len_q));
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign dout = dout_q;
   assign tck  = tck_q;

   // R8
   tms_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tck_q && $past(tck_q)) |-> ($stable(tms) && $stable(tdi)));

   // R8
   tck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !go) |=> !tck_q);

endmodule

// File: rtl/jmseq_script.sv
module jmseq_script
   import jmseq_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 16,
   parameter int BYTE_LIMIT = 'h100,
   parameter int OP_CAPTURE = 'h14,
   parameter int OP_CTRL    = 'h13,
   parameter int OP_ADDR    = 'h83,
   parameter int OP_D2A     = 'h85
) (
   input  logic [4:0]        pc,
   input  logic              is_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output op_t               op
);

   logic        is_byte;
   logic [15:0] cw_wr, cw_rd;

   assign is_byte = (addr < ADDR_W'(BYTE_LIMIT));
   assign cw_wr   = is_byte ? CW_WR_BYTE : CW_WR_WORD;
   assign cw_rd   = is_byte ? CW_RD_BYTE : CW_RD_WORD;

   always_comb begin
      op = '{kind: OP_END, keep: 1'b0, val: '0};
      case (pc)
         5'd0: op = '{OP_IR,    1'b0, 32'(OP_CAPTURE)};
         5'd1: op = '{OP_DR_D,  1'b0, 32'd0};
         5'd2: op = '{OP_CHECK, 1'b0, 32'd0};
         5'd3: op = '{OP_CLK_LO, 1'b0, 32'd0};
         5'd4: op = '{OP_IR,    1'b0, 32'(OP_CTRL)};
         5'd5: op = '{OP_DR_D,  1'b0, 32'(is_wr ? cw_wr : cw_rd)};
         5'd6: op = '{OP_IR,    1'b0, 32'(OP_ADDR)};
         5'd7: op = '{OP_DR_A,  1'b0, 32'(addr)};
         default: begin
            if (is_wr) begin
               case (pc)
                  5'd8:  op = '{OP_CLK_HI, 1'b0, 32'd0};
                  5'd9:  op = '{OP_IR,     1'b0, 32'(OP_D2A)};
                  5'd10: op = '{OP_DR_D,   1'b0, 32'(wdata)};
                  5'd11: op = '{OP_CLK_LO, 1'b0, 32'd0};
                  5'd12: op = '{OP_IR,     1'b0, 32'(OP_CTRL)};
                  5'd13: op = '{OP_DR_D,   1'b0, 32'(CW_RELEASE)};
                  5'd14: op = '{OP_CLK_HI, 1'b0, 32'd0};
                  5'd15: op = '{OP_CLK_LO, 1'b0, 32'd0};
                  5'd16: op = '{OP_CLK_HI, 1'b0, 32'd0};
                  default: ;
               endcase
            end else begin
               case (pc)
                  5'd8:  op = '{OP_IR,     1'b0, 32'(OP_D2A)};
                  5'd9:  op = '{OP_CLK_HI, 1'b0, 32'd0};
                  5'd10: op = '{OP_CLK_LO, 1'b0, 32'd0};
                  5'd11: op = '{OP_DR_D,   1'b1, 32'd0};
                  5'd12: op = '{OP_CLK_HI, 1'b0, 32'd0};
                  5'd13: op = '{OP_CLK_LO, 1'b0, 32'd0};
                  5'd14: op = '{OP_CLK_HI, 1'b0, 32'd0};
                  default: ;
               endcase
            end
         end
      endcase
   end

endmodule

// File: rtl/jtag_mem_seq.sv
module jtag_mem_seq
   import jmseq_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 16,
   parameter int IR_W       = 8,
   parameter int HALF_DIV   = 2,
   parameter int TCLK_HOLD  = 2,
   parameter int MAX_POLLS  = 8,
   parameter int BYTE_LIMIT = 'h100,
   parameter int OP_CAPTURE = 'h14,
   parameter int OP_CTRL    = 'h13,
   parameter int OP_ADDR    = 'h83,
   parameter int OP_D2A     = 'h85
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              cmd_busy,
   output logic              cmd_done,
   output logic              cmd_err,
   output logic [DATA_W-1:0] cmd_rdata,
   output logic              jtag_tck,
   output logic              jtag_tms,
   output logic              jtag_tdi,
   input  logic              jtag_tdo,
   output logic              tgt_clk
);

   localparam int MAX_LEN = (ADDR_W > DATA_W) ? ((ADDR_W > IR_W) ? ADDR_W : IR_W)
                                              : ((DATA_W > IR_W) ? DATA_W : IR_W);
   localparam int LEN_W   = $clog2(MAX_LEN + 1);
   localparam int PW      = $clog2(MAX_POLLS + 1);
   localparam int HW      = $clog2(TCLK_HOLD + 1);

   if (DATA_W < 16 || MAX_LEN > 32) begin : g_bad_width
      $error("DATA_W must be at least 16 and no shift may exceed 32 bits");
   end
   if (MAX_POLLS < 1 || TCLK_HOLD < 1) begin : g_bad_count
      $error("MAX_POLLS and TCLK_HOLD must be at least 1");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_SHIFT, ST_DWELL} st_e;

   st_e               st_q;
   logic [4:0]        pc_q;
   logic              wr_q, err_q, done_q, tclk_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q, stat_q;
   logic [PW-1:0]     polls_q;
   logic [HW-1:0]     hold_q;
   op_t               op;
   logic              w_go, w_busy, w_done, w_tck;
   logic [LEN_W-1:0]  w_len;
   logic [MAX_LEN-1:0] w_dout;

   jmseq_script #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_LIMIT(BYTE_LIMIT),
      .OP_CAPTURE(OP_CAPTURE), .OP_CTRL(OP_CTRL), .OP_ADDR(OP_ADDR), .OP_D2A(OP_D2A)
   ) i_script (
      .pc(pc_q), .is_wr(wr_q), .addr(addr_q), .wdata(wdata_q), .op(op)
   );

   assign w_go  = (st_q == ST_RUN) &&
                  (op.kind == OP_IR || op.kind == OP_DR_D || op.kind == OP_DR_A);
   assign w_len = (op.kind == OP_IR)   ? LEN_W'(IR_W)   :
                  (op.kind == OP_DR_A) ? LEN_W'(ADDR_W) : LEN_W'(DATA_W);

   jmseq_tap_walker #(.MAX_LEN(MAX_LEN), .HALF_DIV(HALF_DIV)) i_walker (
      .clk(clk), .rst_n(rst_n), .go(w_go), .is_ir(op.kind == OP_IR),
      .len(w_len), .din(op.val[MAX_LEN-1:0]), .busy(w_busy), .done(w_done),
      .dout(w_dout), .tck(w_tck), .tms(jtag_tms), .tdi(jtag_tdi), .tdo(jtag_tdo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         pc_q    <= '0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         stat_q  <= '0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
         tclk_q  <= 1'b1;
         polls_q <= '0;
         hold_q  <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: if (cmd_start) begin
               st_q    <= ST_RUN;
               pc_q    <= '0;
               polls_q <= '0;
               wr_q    <= cmd_write;
               addr_q  <= cmd_addr;
               wdata_q <= cmd_wdata;
               err_q   <= 1'b0;
            end
            ST_RUN: begin
               case (op.kind)
                  OP_IR, OP_DR_D, OP_DR_A: st_q <= ST_SHIFT;
                  OP_CLK_LO, OP_CLK_HI: begin
                     tclk_q <= (op.kind == OP_CLK_HI);
                     hold_q <= '0;
                     st_q   <= ST_DWELL;
                  end
                  OP_CHECK: begin
                     if ((stat_q[15:0] & READY_MASK) != 16'h0) begin
                        pc_q <= pc_q + 1'b1;
                     end else if (wr_q) begin
                        err_q  <= 1'b1;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                     end else if (polls_q == PW'(MAX_POLLS - 1)) begin
                        err_q   <= 1'b1;
                        rdata_q <= DATA_W'(FAIL_WORD);
                        done_q  <= 1'b1;
                        st_q    <= ST_IDLE;
                     end else begin
                        polls_q <= polls_q + 1'b1;
                        pc_q    <= '0;
                     end
                  end
                  default: begin
                     done_q <= 1'b1;
                     st_q   <= ST_IDLE;
                  end
               endcase
            end
            ST_SHIFT: if (w_done) begin
               stat_q <= w_dout[DATA_W-1:0];
               if (op.keep) rdata_q <= w_dout[DATA_W-1:0];
               pc_q <= pc_q + 1'b1;
               st_q <= ST_RUN;
            end
            default: begin
               if (hold_q == HW'(TCLK_HOLD - 1)) begin
                  pc_q <= pc_q + 1'b1;
                  st_q <= ST_RUN;
               end else begin
                  hold_q <= hold_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign cmd_busy  = (st_q != ST_IDLE);
   assign cmd_done  = done_q;
   assign cmd_err   = err_q;
   assign cmd_rdata = rdata_q;
   assign jtag_tck  = w_tck;
   assign tgt_clk   = tclk_q;

   // R9
   tclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tclk_q) |-> (!w_busy && !w_tck));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> !cmd_done);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> !cmd_busy);

   // R3
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_err) |-> cmd_done);

   // R10
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_busy && !cmd_start) |=> ($stable(cmd_err) && $stable(cmd_rdata)));

endmodule

// File: tb/test_jtag_mem_seq.sv
module test_jtag_mem_seq;

   localparam int CLK_PERIOD = 10;
   localparam int POLLS      = 3;
   localparam int C_CAP  = 'h14;
   localparam int C_CTRL = 'h13;
   localparam int C_ADDR = 'h83;
   localparam int C_D2A  = 'h85;
   localparam int EV_IR = 1, EV_DR = 2, EV_RISE = 3, EV_FALL = 4;
   // TAP states
   localparam int T_TLR = 0, T_IDLE = 1, T_SELDR = 2, T_CAPDR = 3, T_SHDR = 4,
                  T_EX1DR = 5, T_PDR = 6, T_EX2DR = 7, T_UPDR = 8, T_SELIR = 9,
                  T_CAPIR = 10, T_SHIR = 11, T_EX1IR = 12, T_PIR = 13, T_EX2IR = 14,
                  T_UPIR = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic        cmd_write = 1'b0;
   logic [19:0] cmd_addr = '0;
   logic [15:0] cmd_wdata = '0;
   logic        cmd_busy, cmd_done, cmd_err;
   logic [15:0] cmd_rdata;
   logic        tck, tms, tdi, tclk;
   logic        tdo = 1'b0;

   int n_chk = 0, n_fail = 0;

   // target model state
   int          ev_k [0:2047];
   int          ev_v [0:2047];
   int          ev_n = 0;
   int          ts = T_IDLE;
   logic [31:0] sr = '0;
   int          nb = 0;
   logic [7:0]  ir_sr = '0, ir_reg = '0;
   int          irn = 0;
   logic        tck_prev = 1'b0, tclk_prev = 1'b1;
   int          cap_cnt = 0;
   // per-command settings, written by the stimulus process
   int          cap_base = 0;
   int          fail_polls = 0;
   logic [15:0] stat_ok = 16'h0001;
   logic [19:0] cur_addr = '0;

   // expected log
   int exp_k [0:255];
   int exp_v [0:255];
   int exp_n = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   jtag_mem_seq #(
      .HALF_DIV(2), .TCLK_HOLD(2), .MAX_POLLS(POLLS),
      .OP_CAPTURE(C_CAP), .OP_CTRL(C_CTRL), .OP_ADDR(C_ADDR), .OP_D2A(C_D2A)
   ) i_jtag_mem_seq (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy),
      .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_rdata(cmd_rdata),
      .jtag_tck(tck), .jtag_tms(tms), .jtag_tdi(tdi), .jtag_tdo(tdo), .tgt_clk(tclk)
   );

   function automatic logic [15:0] mem_of(input logic [19:0] a);
      return a[15:0] ^ 16'h5A3C;
   endfunction

   function automatic int tap_next(input int s, input logic m);
      case (s)
         T_TLR:   return m ? T_TLR   : T_IDLE;
         T_IDLE:  return m ? T_SELDR : T_IDLE;
         T_SELDR: return m ? T_SELIR : T_CAPDR;
         T_CAPDR: return m ? T_EX1DR : T_SHDR;
         T_SHDR:  return m ? T_EX1DR : T_SHDR;
         T_EX1DR: return m ? T_UPDR  : T_PDR;
         T_PDR:   return m ? T_EX2DR : T_PDR;
         T_EX2DR: return m ? T_UPDR  : T_SHDR;
         T_UPDR:  return m ? T_SELDR : T_IDLE;
         T_SELIR: return m ? T_TLR   : T_CAPIR;
         T_CAPIR: return m ? T_EX1IR : T_SHIR;
         T_SHIR:  return m ? T_EX1IR : T_SHIR;
         T_EX1IR: return m ? T_UPIR  : T_PIR;
         T_PIR:   return m ? T_EX2IR : T_PIR;
         T_EX2IR: return m ? T_UPIR  : T_SHIR;
         default: return m ? T_SELDR : T_IDLE;
      endcase
   endfunction

   task automatic log_ev(input int k, input int v);
      if (ev_n < 2048) begin
         ev_k[ev_n] = k;
         ev_v[ev_n] = v;
      end
      ev_n++;
   endtask

   // Behavioural target: TAP, status register, memory and clock-edge log
   always @(negedge clk) begin
      if (!rst_n) begin
         ts = T_IDLE;
         tck_prev = 1'b0;
         tclk_prev = 1'b1;
         tdo = 1'b0;
      end else begin
         if (tck && !tck_prev) begin
            case (ts)
               T_CAPDR: begin
                  nb = 0;
                  if (int'(ir_reg) == C_CAP) begin
                     sr = 32'((cap_cnt - cap_base) < fail_polls ? 16'hFCFE : stat_ok);
                     cap_cnt++;
                  end else if (int'(ir_reg) == C_D2A) begin
                     sr = 32'(mem_of(cur_addr));
                  end else begin
                     sr = '0;
                  end
               end
               T_SHDR: begin sr = {tdi, sr[31:1]}; nb++; end
               T_UPDR: log_ev(EV_DR, (nb << 24) | int'(sr >> (32 - nb)));
               T_CAPIR: begin ir_sr = 8'h01; irn = 0; end
               T_SHIR: begin ir_sr = {tdi, ir_sr[7:1]}; irn++; end
               T_UPIR: begin ir_reg = ir_sr; log_ev(EV_IR, (irn << 24) | int'(ir_reg)); end
               default: ;
            endcase
            ts = tap_next(ts, tms);
         end
         if (!tck && tck_prev)
            tdo = (ts == T_SHDR) ? sr[0] : ((ts == T_SHIR) ? ir_sr[0] : 1'b0);
         if (tclk != tclk_prev) log_ev(tclk ? EV_RISE : EV_FALL, 0);
         tck_prev = tck;
         tclk_prev = tclk;
      end
   end

   task automatic check(input logic ok, input string req, input string what,
                        input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic ex(input int k, input int v);
      exp_k[exp_n] = k;
      exp_v[exp_n] = v;
      exp_n++;
   endtask
   task automatic ex_ir(input int op);
      ex(EV_IR, (8 << 24) | op);
   endtask
   task automatic ex_dr(input int len, input int v);
      ex(EV_DR, (len << 24) | v);
   endtask

   // One command: set target behaviour, build the expected log, run, compare
   task automatic run_cmd(input logic wr, input logic [19:0] a, input logic [15:0] wd,
                          input int fails, input logic [15:0] okst, input logic poke);
      int base, polls, waited;
      logic bmode, exp_err;
      base = ev_n;
      cap_base = cap_cnt;
      fail_polls = fails;
      stat_ok = okst;
      cur_addr = a;
      bmode = (a < 20'h100);
      exp_n = 0;
      // R1: status check, repeated on reads (R2), single on writes (R3)
      polls = wr ? 1 : ((fails < POLLS) ? fails + 1 : POLLS);
      exp_err = wr ? (fails > 0) : (fails >= POLLS);
      for (int i = 0; i < polls; i++) begin
         ex_ir(C_CAP);
         ex_dr(16, 0);
      end
      if (!exp_err) begin
         // R4 control words, R5 address shift
         ex(EV_FALL, 0);
         ex_ir(C_CTRL);
         ex_dr(16, wr ? (bmode ? 'h0510 : 'h0500) : (bmode ? 'h0511 : 'h0501));
         ex_ir(C_ADDR);
         ex_dr(20, int'(a));
         if (wr) begin
            // R6 write order
            ex(EV_RISE, 0);
            ex_ir(C_D2A);
            ex_dr(16, int'(wd));
            ex(EV_FALL, 0);
            ex_ir(C_CTRL);
            ex_dr(16, 'h0501);
            ex(EV_RISE, 0);
         end else begin
            // R7 read order
            ex_ir(C_D2A);
            ex(EV_RISE, 0);
            ex(EV_FALL, 0);
            ex_dr(16, 0);
            ex(EV_RISE, 0);
         end
         ex(EV_FALL, 0);
         ex(EV_RISE, 0);
      end

      cmd_write = wr;
      cmd_addr  = a;
      cmd_wdata = wd;
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      waited = 0;
      while (!cmd_done && waited < 20000) begin
         if (poke && waited == 40) begin
            // R10: start during a command with different arguments
            cmd_write = ~wr;
            cmd_addr  = 20'h00003;
            cmd_wdata = ~wd;
            cmd_start = 1'b1;
         end else begin
            cmd_start = 1'b0;
         end
         @(negedge clk);
         waited++;
      end
      cmd_start = 1'b0;
      // watchdog for this command
      check(cmd_done, "R10", "done reached before watchdog", waited, 0);
      check(!cmd_busy, "R10", "busy low with done", int'(cmd_busy), 0);
      check(cmd_err == exp_err, wr ? "R3" : "R2", "error flag", int'(cmd_err), int'(exp_err));
      if (!wr) begin
         if (exp_err)
            check(cmd_rdata == 16'hBABE, "R2", "failed-read data", int'(cmd_rdata), 'hBABE);
         else
            check(cmd_rdata == mem_of(a), "R7", "read data", int'(cmd_rdata), int'(mem_of(a)));
      end
      // R1 R4 R5 R6 R7 R8 R9: exact order of shifts and target-clock edges
      begin
         int bad;
         bad = -1;
         if (ev_n - base != exp_n) bad = exp_n;
         else
            for (int i = 0; i < exp_n; i++)
               if (bad < 0 && (ev_k[base+i] != exp_k[i] || ev_v[base+i] != exp_v[i])) bad = i;
         if (bad >= 0 && bad < exp_n && ev_n - base == exp_n)
            check(1'b0, wr ? "R6" : "R7", "sequence entry",
                  ev_v[base+bad] | (ev_k[base+bad] << 28), exp_v[bad] | (exp_k[bad] << 28));
         else
            check(bad < 0, wr ? "R6" : "R7", "sequence length", ev_n - base, exp_n);
      end
      @(negedge clk);
      check(!cmd_done, "R10", "done lasts one cycle", int'(cmd_done), 0);
      check(!cmd_busy && tclk, "R9", "idle with target clock high", int'(tclk), 1);
   endtask

   initial begin
      logic [19:0] addrs [0:5];
      logic [15:0] oks [0:2];
      addrs[0] = 20'h00000; addrs[1] = 20'h000FF; addrs[2] = 20'h00100;
      addrs[3] = 20'h00101; addrs[4] = 20'hABCDE; addrs[5] = 20'hFFFFF;
      oks[0] = 16'h0001; oks[1] = 16'h0100; oks[2] = 16'h0200;

      repeat (3) @(negedge clk);
      // R9 R8 R10: reset state
      check(tclk == 1'b1, "R9", "reset target clock", int'(tclk), 1);
      check(tck == 1'b0 && tms == 1'b0, "R8", "reset tck/tms", int'({tck, tms}), 0);
      check(!cmd_busy && !cmd_done, "R10", "reset busy/done", int'({cmd_busy, cmd_done}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 6; i++)
         for (int w = 0; w < 2; w++)
            run_cmd(w[0], addrs[i], 16'h1234 + 16'(i * 'h1111) ^ 16'(w * 'hF0F0),
                    (i + w) % 3, oks[(i + w + 1) % 3], (i == 1 && w == 0));
      // R2: reads that never see a ready status
      run_cmd(1'b0, 20'h00200, 16'h0, POLLS, 16'h0001, 1'b0);
      run_cmd(1'b0, 20'h00010, 16'h0, POLLS + 2, 16'h0001, 1'b0);
      // R3: write that fails, then a clean write to show recovery
      run_cmd(1'b1, 20'h00050, 16'hC3C3, 1, 16'h0001, 1'b0);
      run_cmd(1'b1, 20'h00050, 16'h3C3C, 0, 16'h0301, 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule